// File: doc/BRIEF.md
# Lane-Confined Byte Permutation Unit

This unit rearranges the bytes of two 256-bit operands, A and B, into one 256-bit result. The operation is picked by an opcode. The operand is split into two 128-bit lanes, and every operation is applied to each lane on its own; no byte ever moves from one lane into the other.

Four operations are provided:

- A table lookup, in which each byte of B steers the matching result byte.
- A concatenate-and-shift align, driven by an 8-bit byte count.
- Two interleaves, which merge elements from the lower or upper 64-bit half of each lane. The element width is 8, 16, 32 or 64 bits.

A request is presented for one cycle with `in_valid`. The result appears one clock later from a single output register, together with `out_valid`.

Top module: `lane_permute_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low), `out_valid` is 0 and `out_data` is all zero.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `out_data` loads only when `in_valid` is 1, and holds its value in cycles where `in_valid` is 0.
- R3: Opcode 0 is the table lookup. For a result byte whose control byte in B has bit 7 clear, bits 3:0 of that control byte select a byte index 0..15 within the same lane of A. Bits 6:4 of the control byte have no effect.
- R4: Opcode 0: when bit 7 of the control byte is 1, the matching result byte is 0x00.
- R5: Opcode 1 is the align. Within each lane, the lane of A is placed above the lane of B to form a 32-byte value. That value is shifted right by `imm` bytes, and its low 16 bytes form the result lane.
- R6: Opcode 1 with `imm` from 16 to 31 fills the vacated upper bytes with zeros. With `imm` of 32 or more, the result lane is all zero.
- R7: Opcode 2 is the low interleave. `elem_sel` gives the element width: 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. Within each lane, the elements of the lower 8 bytes of A and B are merged. A supplies the even-numbered result elements and B the odd-numbered ones, both in ascending order. The upper 8 bytes of each lane are ignored.
- R8: Opcode 3 is the high interleave. It works like R7 but takes its elements from the upper 8 bytes of each lane, so at byte width result byte 0 is A byte 8.
- R9: No result byte in one 128-bit lane depends on operand bytes of the other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation: 0 lookup, 1 align, 2 low interleave, 3 high interleave |
| elem_sel | input | 2 | Interleave element width: 1, 2, 4 or 8 bytes |
| imm | input | 8 | Align byte count |
| opnd_a | input | 256 | Operand A |
| opnd_b | input | 256 | Operand B (control bytes for the lookup) |
| out_valid | output | 1 | Result strobe |
| out_data | output | 256 | Registered result |

## Verification
The lookup is driven with control bytes that together cover all 256 values. This shows whether bits 6:4 are ignored and whether bit 7 zeroes the byte, and random control data exercises general indexing. The align count is swept over every value from 0 to 255. That separates in-lane shifts, zero fill from above, and the all-zero region beyond 31. Both interleaves are run at each of the four element widths with random data, which tells apart element grouping, even/odd source order and the choice of half. Operands whose two lanes carry different fixed patterns show any byte leaking between lanes, and a hold step confirms the register keeps its value when no request is presented.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

  localparam int LANE_BYTES = 16;
  localparam int HALF_BYTES = LANE_BYTES / 2;
  localparam int LANE_W     = LANE_BYTES * 8;
  localparam int IDX_W      = $clog2(LANE_BYTES);

  typedef enum logic [1:0] {
    OP_TBL    = 2'd0,
    OP_ALIGN  = 2'd1,
    OP_ILV_LO = 2'd2,
    OP_ILV_HI = 2'd3
  } op_e;

  typedef logic [LANE_W-1:0] lane_t;

  // lookup: top control bit zeroes, low index bits select a byte of the lane
  function automatic logic [7:0] tbl_pick(lane_t src, logic [7:0] ctl);
    logic [IDX_W-1:0] idx;
    idx = ctl[IDX_W-1:0];
    if (ctl[7]) return 8'h00;
    return src[idx*8 +: 8];
  endfunction

  // align: byte r of ({hi,lo} >> cnt bytes)
  function automatic logic [7:0] align_pick(lane_t hi, lane_t lo, logic [7:0] cnt, int r);
    int pos;
    pos = int'(cnt) + r;
    if (pos < LANE_BYTES) return lo[pos*8 +: 8];
    if (pos < 2*LANE_BYTES) return hi[(pos-LANE_BYTES)*8 +: 8];
    return 8'h00;
  endfunction

  // interleave: result byte r, element width 2**esz bytes, half chosen by upper
  function automatic logic [7:0] ilv_pick(lane_t a, lane_t b, int r, logic [1:0] esz, logic upper);
    int ebytes, k, w, pos;
    ebytes = 1 << esz;
    k      = r >> esz;
    w      = r & (ebytes - 1);
    pos    = (upper ? HALF_BYTES : 0) + (k >> 1) * ebytes + w;
    if ((k & 1) != 0) return b[pos*8 +: 8];
    return a[pos*8 +: 8];
  endfunction

endpackage

// File: rtl/lpu_tbl_lane.sv
module lpu_tbl_lane
  import lpu_pkg::*;
(
  input  lane_t src,
  input  lane_t ctl,
  output lane_t res
);
  for (genvar r = 0; r < LANE_BYTES; r++) begin : g_byte
    assign res[r*8 +: 8] = tbl_pick(src, ctl[r*8 +: 8]);
  end
endmodule

// File: rtl/lpu_align_lane.sv
module lpu_align_lane
  import lpu_pkg::*;
(
  input  lane_t      hi,
  input  lane_t      lo,
  input  logic [7:0] cnt,
  output lane_t      res
);
  for (genvar r = 0; r < LANE_BYTES; r++) begin : g_byte
    assign res[r*8 +: 8] = align_pick(hi, lo, cnt, r);
  end
endmodule

// File: rtl/lpu_ilv_lane.sv
module lpu_ilv_lane
  import lpu_pkg::*;
(
  input  lane_t      a,
  input  lane_t      b,
  input  logic [1:0] esz,
  input  logic       upper,
  output lane_t      res
);
  for (genvar r = 0; r < LANE_BYTES; r++) begin : g_byte
    assign res[r*8 +: 8] = ilv_pick(a, b, r, esz, upper);
  end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
  import lpu_pkg::*;
#(
  parameter int LANES  = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [1:0]        elem_sel,
  input  logic [7:0]        imm,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  op_e              op;
  logic             ilv_upper;
  logic [DATA_W-1:0] nxt_data;

  assign op        = op_e'(op_sel);
  assign ilv_upper = (op == OP_ILV_HI);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_t la, lb, r_tbl, r_aln, r_ilv;
    assign la = opnd_a[l*LANE_W +: LANE_W];
    assign lb = opnd_b[l*LANE_W +: LANE_W];

    lpu_tbl_lane u_tbl (.src(la), .ctl(lb), .res(r_tbl));
    lpu_align_lane u_aln (.hi(la), .lo(lb), .cnt(imm), .res(r_aln));
    lpu_ilv_lane u_ilv (.a(la), .b(lb), .esz(elem_sel), .upper(ilv_upper), .res(r_ilv));

    always_comb begin
      unique case (op)
        OP_TBL:   nxt_data[l*LANE_W +: LANE_W] = r_tbl;
        OP_ALIGN: nxt_data[l*LANE_W +: LANE_W] = r_aln;
        default:  nxt_data[l*LANE_W +: LANE_W] = r_ilv;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt_data;
    end
  end

endmodule

// File: rtl/lpu_checker.sv
module lpu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] op_sel,
  input logic [7:0] imm,
  input logic [7:0] a_byte0,
  input logic [7:0] a_byte8,
  input logic [7:0] a_byte16,
  input logic       b_top0,
  input logic [7:0] b_ctl16,
  input logic       out_valid,
  input logic [255:0] out_data
);

  // R2: valid is delayed by exactly one cycle
  a_r2_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2: no request, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  // R4: top control bit zeroes the byte
  a_r4_zero_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd0 && b_top0) |=> out_data[7:0] == 8'h00);
  // R6: counts of 32 and above clear the whole result
  a_r6_far_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd1 && imm >= 8'd32) |=> out_data == '0);
  // R7: first result byte of a low interleave is A byte 0 at any width
  a_r7_lo_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd2) |=> out_data[7:0] == $past(a_byte0));
  // R8: first result byte of a high interleave is A byte 8
  a_r8_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd3) |=> out_data[7:0] == $past(a_byte8));
  // R9: upper lane index 0 refers to the upper lane's own byte 0
  a_r9_lane_local: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'd0 && b_ctl16 == 8'h00) |=> out_data[135:128] == $past(a_byte16));

endmodule

bind lane_permute_unit lpu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .imm(imm),
  .a_byte0(opnd_a[7:0]), .a_byte8(opnd_a[71:64]), .a_byte16(opnd_a[135:128]),
  .b_top0(opnd_b[7]), .b_ctl16(opnd_b[135:128]),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_lane_permute_unit.sv
module test_lane_permute_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op_sel = '0;
  logic [1:0]   elem_sel = '0;
  logic [7:0]   imm = '0;
  logic [255:0] opnd_a = '0;
  logic [255:0] opnd_b = '0;
  logic         out_valid;
  logic [255:0] out_data;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lane_permute_unit i_lane_permute_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .elem_sel(elem_sel), .imm(imm), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  // independent model, lane by lane
  function automatic logic [255:0] model(logic [1:0] op, logic [1:0] esz, logic [7:0] n,
                                         logic [255:0] a, logic [255:0] b);
    logic [255:0] res;
    res = '0;
    for (int l = 0; l < 2; l++) begin
      logic [127:0] la, lb, lr;
      la = a[l*128 +: 128];
      lb = b[l*128 +: 128];
      lr = '0;
      if (op == 2'd0) begin
        for (int i = 0; i < 16; i++) begin
          logic [7:0] c;
          logic [127:0] sh;
          c  = lb[i*8 +: 8];
          sh = la >> (int'(c[3:0]) * 8);
          lr[i*8 +: 8] = c[7] ? 8'h00 : sh[7:0];
        end
      end else if (op == 2'd1) begin
        logic [255:0] cat;
        cat = {la, lb} >> (int'(n) * 8);
        lr  = cat[127:0];
      end else begin
        int eb, base;
        logic [127:0] mask;
        eb   = 1 << esz;
        base = (op == 2'd3) ? 64 : 0;
        mask = (128'd1 << (eb * 8)) - 128'd1;
        for (int j = 0; j < 8 / eb; j++) begin
          lr = lr | (((la >> (base + j*eb*8)) & mask) << (2*j*eb*8));
          lr = lr | (((lb >> (base + j*eb*8)) & mask) << ((2*j+1)*eb*8));
        end
      end
      res[l*128 +: 128] = lr;
    end
    return res;
  endfunction

  task automatic check(string req, logic [255:0] got, logic [255:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(string req, logic [1:0] op, logic [1:0] esz, logic [7:0] n,
                       logic [255:0] a, logic [255:0] b);
    @(negedge clk);
    op_sel = op; elem_sel = esz; imm = n; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {255'd0, out_valid}, 256'd1);
    check(req, out_data, model(op, esz, n, a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [255:0] ctl, a, b, held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {255'd0, out_valid}, '0);
    check("R1 data", out_data, '0);
    rst_n = 1'b1;

    // R3 and R4: control bytes covering all 256 values
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 32; i++) ctl[i*8 +: 8] = 8'(k*32 + i);
      apply(k < 4 ? "R3" : "R4", 2'd0, 2'd0, 8'd0, rnd256(), ctl);
    end
    for (int k = 0; k < 16; k++) apply("R3_R4", 2'd0, 2'd0, 8'd0, rnd256(), rnd256());

    // R5 and R6: every align count
    for (int n = 0; n < 256; n++)
      apply(n < 16 ? "R5" : "R6", 2'd1, 2'd0, 8'(n), rnd256(), rnd256());

    // R7 and R8: each element width
    for (int e = 0; e < 4; e++) begin
      for (int k = 0; k < 6; k++) begin
        apply("R7", 2'd2, 2'(e), 8'($urandom()), rnd256(), rnd256());
        apply("R8", 2'd3, 2'(e), 8'($urandom()), rnd256(), rnd256());
      end
    end

    // R9: lanes with distinct fills
    a = {{16{8'h5A}}, {16{8'hA5}}};
    b = {{16{8'h3C}}, {16{8'hC3}}};
    apply("R9", 2'd0, 2'd0, 8'd0, a, {32{8'h0F}});
    apply("R9", 2'd1, 2'd0, 8'd20, a, b);
    apply("R9", 2'd2, 2'd3, 8'd0, a, b);
    apply("R9", 2'd3, 2'd0, 8'd0, a, b);

    // R2: hold when no request
    held = out_data;
    @(negedge clk);
    op_sel = 2'd1; opnd_a = rnd256(); opnd_b = rnd256(); imm = 8'd3;
    @(negedge clk);
    check("R2 valid", {255'd0, out_valid}, '0);
    check("R2 hold", out_data, held);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule